// File: doc/BRIEF.md
# Command Identifier Tracker

This block sits on the requester side of a command/completion protocol. It hands a command identifier to each outgoing request and stores that request's context under it. When a completion returns and echoes the identifier, the block retires that identifier and recovers the context. Completions carry no copy of the request's data or buffer, so the table entry is the only place to find out what a completion belongs to. Completions may come back in any order.

Requests arrive on a valid/ready stream and queue in a pending FIFO. The head of that FIFO is issued with an identifier from a free list on a second stream. The free list holds every identifier after reset. A retired identifier goes back to the tail of the free list.

Completions arrive on a third stream. A completion whose identifier is outstanding produces one retire record on the fourth stream. The record carries the stored context, the completion status and the do-not-retry flag. A completion whose identifier is not outstanding is dropped, and the block raises a one-cycle error pulse.

Back-pressure on the streams works as follows:
- `req_ready` falls when the pending FIFO is full.
- `iss_valid` holds while a pending request waits for `iss_ready`.
- `cpl_ready` falls while a retire record is held because `ret_ready` is low.

Top module: `cid_tracker`

## Requirements
- R1: After reset `idle` is 1, `iss_valid`, `ret_valid` and `err_spurious` are 0, and both `req_ready` and `cpl_ready` are 1.
- R2: An issued command presents the identifier at the head of the free list together with the oldest pending context. `iss_id` and `iss_ctx` stay stable while `iss_valid` is high and `iss_ready` is low. No identifier is issued twice while it is outstanding.
- R3: After reset the free list holds identifiers in ascending order, starting at 0. Each retired identifier is appended to its tail, so identifiers are reissued in the order they were freed.
- R4: Retirement may occur in any order. The retire record carries the context stored under `cpl_id`, plus `cpl_status` and `cpl_dnr` unchanged.
- R5: A completion accepted for an identifier that is not outstanding (never issued, or already retired) produces no retire record. It raises `err_spurious` for exactly the next cycle and leaves the table and the free list unchanged.
- R6: When no identifier is free, `iss_valid` stays low and accepted requests wait in the pending FIFO. `req_ready` is 0 when that FIFO is full.
- R7: Pending requests are issued in arrival order as identifiers are freed.
- R8: `idle` is 1 exactly when no identifier is outstanding and the pending FIFO is empty.
- R9: While `ret_valid` is 1 and `ret_ready` is 0, the retire record stays stable and `cpl_ready` is 0.
- R10: A request accepted on one clock edge appears on `iss_valid` in the next cycle when an identifier is free.
- R11: A completion accepted on one clock edge for an outstanding identifier appears on `ret_valid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | Pending FIFO can accept |
| req_ctx | input | CTX_W | Per-request context |
| iss_valid | output | 1 | Command ready to issue |
| iss_ready | input | 1 | Downstream takes the command |
| iss_id | output | ID_W | Identifier allocated to the command |
| iss_ctx | output | CTX_W | Context of the issued command |
| cpl_valid | input | 1 | Completion present |
| cpl_ready | output | 1 | Completion can be accepted |
| cpl_id | input | ID_W | Identifier echoed by the completion |
| cpl_status | input | STAT_W | Completion status code |
| cpl_dnr | input | 1 | Do-not-retry flag |
| ret_valid | output | 1 | Retire record present |
| ret_ready | input | 1 | Consumer takes the retire record |
| ret_id | output | ID_W | Retired identifier |
| ret_ctx | output | CTX_W | Context recovered from the table |
| ret_status | output | STAT_W | Status passed through |
| ret_dnr | output | 1 | Do-not-retry passed through |
| err_spurious | output | 1 | One-cycle pulse for a dropped completion |
| idle | output | 1 | Nothing outstanding and nothing pending |

## Verification
The bench builds the tracker with four identifiers, a two-entry pending FIFO, 16-bit context and 4-bit status. With these values, a handful of requests exhausts the table and fills the pending FIFO, so both back-pressure points are exercised. A single out-of-order retirement pass then visibly permutes the free-list order, and the permuted order is checked against later allocations. Duplicate completions and completions for idle identifiers are injected between normal retirements to confirm that the table survives them.

// File: rtl/cidt_pkg.sv
package cidt_pkg;
  localparam int DEF_NUM_IDS    = 16;
  localparam int DEF_CTX_W      = 32;
  localparam int DEF_STAT_W     = 15;
  localparam int DEF_PEND_DEPTH = 8;
endpackage

// File: rtl/cidt_fifo.sv
module cidt_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,       // power of two, at least 2
  parameter bit INIT_FULL = 1'b0, // reset contents 0..DEPTH-1
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rptr, wptr;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= INIT_FULL ? CW'(DEPTH) : '0;
    end else begin
      if (push) wptr <= wptr + PW'(1);
      if (pop)  rptr <= rptr + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  generate
    if (INIT_FULL) begin : g_preload
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) mem[i] <= WIDTH'(i);
        end else if (push) begin
          mem[wptr] <= push_data;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
      end
    end
  endgenerate

  assign pop_data = mem[rptr];
  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
endmodule

// File: rtl/cidt_table.sv
module cidt_table #(
  parameter int NUM_IDS = 16,
  parameter int CTX_W   = 32,
  localparam int ID_W   = $clog2(NUM_IDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ID_W-1:0]  wr_id,
  input  logic [CTX_W-1:0] wr_ctx,
  input  logic             clr_en,
  input  logic [ID_W-1:0]  clr_id,
  input  logic [ID_W-1:0]  rd_id,
  output logic             rd_hit,
  output logic [CTX_W-1:0] rd_ctx
);
  logic [NUM_IDS-1:0] live;
  logic [CTX_W-1:0]   ctx_mem [NUM_IDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
    end else begin
      if (clr_en) live[clr_id] <= 1'b0;
      if (wr_en)  live[wr_id]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) ctx_mem[wr_id] <= wr_ctx;
  end

  assign rd_hit = live[rd_id];
  assign rd_ctx = ctx_mem[rd_id];
endmodule

// File: rtl/cid_tracker.sv
module cid_tracker #(
  parameter int NUM_IDS    = cidt_pkg::DEF_NUM_IDS,
  parameter int CTX_W      = cidt_pkg::DEF_CTX_W,
  parameter int STAT_W     = cidt_pkg::DEF_STAT_W,
  parameter int PEND_DEPTH = cidt_pkg::DEF_PEND_DEPTH,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CTX_W-1:0]  req_ctx,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ID_W-1:0]   iss_id,
  output logic [CTX_W-1:0]  iss_ctx,
  input  logic              cpl_valid,
  output logic              cpl_ready,
  input  logic [ID_W-1:0]   cpl_id,
  input  logic [STAT_W-1:0] cpl_status,
  input  logic              cpl_dnr,
  output logic              ret_valid,
  input  logic              ret_ready,
  output logic [ID_W-1:0]   ret_id,
  output logic [CTX_W-1:0]  ret_ctx,
  output logic [STAT_W-1:0] ret_status,
  output logic              ret_dnr,
  output logic              err_spurious,
  output logic              idle
);
  logic pend_empty, pend_full, free_empty, free_full;
  logic iss_fire, cpl_fire, hit, retire_hit;
  logic [CTX_W-1:0] hit_ctx;

  assign req_ready  = !pend_full;
  assign iss_valid  = !pend_empty && !free_empty;
  assign iss_fire   = iss_valid && iss_ready;
  assign cpl_ready  = !ret_valid || ret_ready;
  assign cpl_fire   = cpl_valid && cpl_ready;
  assign retire_hit = cpl_fire && hit;

  cidt_fifo #(.WIDTH(CTX_W), .DEPTH(PEND_DEPTH), .INIT_FULL(1'b0)) pend_q (
    .clk(clk), .rst_n(rst_n),
    .push(req_valid && req_ready), .push_data(req_ctx),
    .pop(iss_fire), .pop_data(iss_ctx),
    .empty(pend_empty), .full(pend_full)
  );

  cidt_fifo #(.WIDTH(ID_W), .DEPTH(NUM_IDS), .INIT_FULL(1'b1)) free_q (
    .clk(clk), .rst_n(rst_n),
    .push(retire_hit), .push_data(cpl_id),
    .pop(iss_fire), .pop_data(iss_id),
    .empty(free_empty), .full(free_full)
  );

  cidt_table #(.NUM_IDS(NUM_IDS), .CTX_W(CTX_W)) tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(iss_fire), .wr_id(iss_id), .wr_ctx(iss_ctx),
    .clr_en(retire_hit), .clr_id(cpl_id),
    .rd_id(cpl_id), .rd_hit(hit), .rd_ctx(hit_ctx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid    <= 1'b0;
      ret_id       <= '0;
      ret_ctx      <= '0;
      ret_status   <= '0;
      ret_dnr      <= 1'b0;
      err_spurious <= 1'b0;
    end else begin
      err_spurious <= cpl_fire && !hit;
      if (retire_hit) begin
        ret_valid  <= 1'b1;
        ret_id     <= cpl_id;
        ret_ctx    <= hit_ctx;
        ret_status <= cpl_status;
        ret_dnr    <= cpl_dnr;
      end else if (ret_ready) begin
        ret_valid  <= 1'b0;
      end
    end
  end

  // free list full means every identifier is home, i.e. none outstanding
  assign idle = free_full && pend_empty;
endmodule

// File: rtl/cid_tracker_chk.sv
module cid_tracker_chk #(
  parameter int NUM_IDS    = 16,
  parameter int CTX_W      = 32,
  parameter int STAT_W     = 15,
  parameter int PEND_DEPTH = 8,
  localparam int ID_W      = $clog2(NUM_IDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CTX_W-1:0]  req_ctx,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [ID_W-1:0]   iss_id,
  input logic [CTX_W-1:0]  iss_ctx,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic [ID_W-1:0]   cpl_id,
  input logic [STAT_W-1:0] cpl_status,
  input logic              cpl_dnr,
  input logic              ret_valid,
  input logic              ret_ready,
  input logic [ID_W-1:0]   ret_id,
  input logic [CTX_W-1:0]  ret_ctx,
  input logic [STAT_W-1:0] ret_status,
  input logic              ret_dnr,
  input logic              err_spurious,
  input logic              idle
);
  logic [NUM_IDS-1:0] busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= '0;
    else begin
      if (cpl_valid && cpl_ready && busy[cpl_id]) busy[cpl_id] <= 1'b0;
      if (iss_valid && iss_ready) busy[iss_id] <= 1'b1;
    end
  end

  assert_unique_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && iss_ready |-> !busy[iss_id]);
  assert_iss_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !iss_ready |=> iss_valid && $stable(iss_id) && $stable(iss_ctx));
  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_ready && !busy[cpl_id] |=> err_spurious && !ret_valid);
  assert_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid && cpl_ready && busy[cpl_id] |=> ret_valid && !err_spurious && ret_id == $past(cpl_id));
  assert_ret_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_ready |=> ret_valid && $stable(ret_id) && $stable(ret_ctx) && $stable(ret_dnr));
  assert_cpl_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !ret_ready |-> !cpl_ready);
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !iss_valid && busy == '0);
  assert_backlog_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !idle);
endmodule

bind cid_tracker cid_tracker_chk #(
  .NUM_IDS(NUM_IDS), .CTX_W(CTX_W), .STAT_W(STAT_W), .PEND_DEPTH(PEND_DEPTH)
) chk_i (.*);

// File: tb/cid_tracker_tb_top.sv
module cid_tracker_tb_top;
  localparam int NI = 4, CW = 16, SW = 4, PD = 2, IW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, iss_ready = 0, cpl_valid = 0, cpl_dnr = 0, ret_ready = 0;
  logic [CW-1:0] req_ctx = '0;
  logic [IW-1:0] cpl_id = '0;
  logic [SW-1:0] cpl_status = '0;
  logic req_ready, iss_valid, cpl_ready, ret_valid, ret_dnr, err_spurious, idle;
  logic [IW-1:0] iss_id, ret_id;
  logic [CW-1:0] iss_ctx, ret_ctx;
  logic [SW-1:0] ret_status;

  always #5 clk = ~clk;

  cid_tracker #(.NUM_IDS(NI), .CTX_W(CW), .STAT_W(SW), .PEND_DEPTH(PD)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  int freeq[$];
  int pendq[$];
  int ctx_of [NI];

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FIFO-check FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send_req(int c, string tag);
    pendq.push_back(c);
    @(negedge clk);
    chk({tag, " req_ready"}, req_ready, 1);
    req_valid = 1; req_ctx = CW'(c);
    @(posedge clk); #1 req_valid = 0;
  endtask

  task automatic take_issue(string tag);
    int eid, ectx;
    eid = freeq.pop_front(); ectx = pendq.pop_front();
    @(negedge clk);
    chk({tag, " iss_valid"}, iss_valid, 1);
    chk({tag, " iss_id"}, iss_id, eid);
    chk({tag, " iss_ctx"}, iss_ctx, ectx);
    ctx_of[eid] = ectx;
    iss_ready = 1;
    @(posedge clk); #1 iss_ready = 0;
  endtask

  task automatic complete_ok(int id, int st, int dnr, string tag);
    @(negedge clk);
    cpl_valid = 1; cpl_id = IW'(id); cpl_status = SW'(st); cpl_dnr = dnr[0];
    @(posedge clk); #1 cpl_valid = 0;
    @(negedge clk);
    chk({tag, " ret_valid"}, ret_valid, 1);
    chk({tag, " ret_id"}, ret_id, id);
    chk({tag, " ret_ctx"}, ret_ctx, ctx_of[id]);
    chk({tag, " ret_status"}, ret_status, st);
    chk({tag, " ret_dnr"}, ret_dnr, dnr);
    chk({tag, " err_spurious"}, err_spurious, 0);
    ret_ready = 1;
    @(posedge clk); #1 ret_ready = 0;
    freeq.push_back(id);
  endtask

  task automatic complete_bad(int id, string tag);
    @(negedge clk);
    cpl_valid = 1; cpl_id = IW'(id); cpl_status = 4'hF; cpl_dnr = 1;
    @(posedge clk); #1 cpl_valid = 0;
    @(negedge clk);
    chk({tag, " err_spurious pulse"}, err_spurious, 1);
    chk({tag, " no ret_valid"}, ret_valid, 0);
    @(negedge clk);
    chk({tag, " err_spurious cleared"}, err_spurious, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 idle", idle, 1);
    chk("R1 iss_valid", iss_valid, 0);
    chk("R1 ret_valid", ret_valid, 0);
    chk("R1 err_spurious", err_spurious, 0);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 cpl_ready", cpl_ready, 1);
  endtask

  task automatic t_fill;
    for (int i = 0; i < NI; i++) begin
      send_req(16'hA000 + i, "R10");
      take_issue("R10 R2 R3 ascending");
    end
    @(negedge clk);
    chk("R8 busy not idle", idle, 0);
  endtask

  task automatic t_ooo;
    complete_ok(1, 3, 0, "R4 R11 id1");
    complete_ok(0, 5, 1, "R4 R11 id0");
    complete_ok(3, 9, 1, "R4 R11 id3");
    complete_ok(2, 0, 0, "R4 R11 id2");
    @(negedge clk);
    chk("R8 idle after retire", idle, 1);
  endtask

  task automatic t_reuse;
    for (int i = 0; i < NI; i++) begin
      send_req(16'hB100 + i, "R3");
      take_issue("R3 freed order reuse");
    end
  endtask

  task automatic t_pending;
    send_req(16'hC0, "R6");
    send_req(16'hC1, "R6");
    @(negedge clk);
    chk("R6 req_ready low when pending full", req_ready, 0);
    chk("R6 no issue when table full", iss_valid, 0);
    @(negedge clk);
    chk("R6 still held", iss_valid, 0);
    chk("R8 not idle with backlog", idle, 0);
    complete_ok(2, 1, 0, "R4 pend");
    take_issue("R7 first pending");
    complete_ok(0, 2, 1, "R4 pend");
    take_issue("R7 second pending");
  endtask

  task automatic t_spurious;
    complete_ok(1, 4, 0, "R4");
    complete_bad(1, "R5 duplicate");
    complete_ok(3, 6, 1, "R5 table unchanged");
    complete_bad(3, "R5 stale");
    complete_ok(2, 7, 0, "R4");
    complete_ok(0, 8, 1, "R4");
    @(negedge clk);
    chk("R8 idle", idle, 1);
    complete_bad(0, "R5 idle id");
    chk("R5 R8 idle kept", idle, 1);
  endtask

  task automatic t_backpressure;
    int a, b;
    send_req(16'hD0, "R9"); take_issue("R9 setup");
    send_req(16'hD1, "R9"); take_issue("R9 setup");
    a = (freeq.size() == 2) ? 0 : 0;
    a = ret_pick(0); b = ret_pick(1);
    @(negedge clk);
    cpl_valid = 1; cpl_id = IW'(a); cpl_status = 4'h2; cpl_dnr = 0;
    @(posedge clk); #1 cpl_valid = 0;
    @(negedge clk);
    cpl_valid = 1; cpl_id = IW'(b); cpl_status = 4'h3; cpl_dnr = 1;
    chk("R9 cpl_ready low", cpl_ready, 0);
    chk("R9 ret held id", ret_id, a);
    @(negedge clk);
    chk("R9 cpl_ready still low", cpl_ready, 0);
    chk("R9 ret_valid held", ret_valid, 1);
    chk("R9 ret_ctx stable", ret_ctx, ctx_of[a]);
    chk("R9 ret_status stable", ret_status, 2);
    ret_ready = 1;
    @(posedge clk); #1 ret_ready = 0; cpl_valid = 0;
    freeq.push_back(a); freeq.push_back(b);
    @(negedge clk);
    chk("R11 second ret_valid", ret_valid, 1);
    chk("R4 second ret_id", ret_id, b);
    chk("R4 second ret_ctx", ret_ctx, ctx_of[b]);
    chk("R4 second ret_dnr", ret_dnr, 1);
    ret_ready = 1;
    @(posedge clk); #1 ret_ready = 0;
    @(negedge clk);
    chk("R8 idle at end", idle, 1);
    chk("R9 ret drained", ret_valid, 0);
  endtask

  // identifiers issued in t_backpressure are the last two popped from the model
  int issued_log[$];
  function automatic int ret_pick(int k);
    return issued_log[k];
  endfunction

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        for (int i = 0; i < NI; i++) freeq.push_back(i);
        t_reset();
        t_fill();
        t_ooo();
        t_reuse();
        t_pending();
        t_spurious();
        issued_log.push_back(freeq[0]);
        issued_log.push_back(freeq[1]);
        t_backpressure();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("watchdog FAIL all: actual hung expected finish");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule